// File: doc/BRIEF.md
# Processor-Mode Banked Register File

This block holds the sixteen 32-bit general registers of a processor that runs in several privilege modes. Some register numbers have private copies per mode. Index 0 to 7 and index 15 are one physical register each. Index 8 to 12 have one copy for the fast-interrupt mode and one shared by every other mode. Index 13 and 14 have one copy per mode, and User and System share a single copy. A saved-status word exists for the five exception modes only.

The block owns the current mode. A mode-change request stores the live copies of the outgoing mode and brings in those of the incoming mode, all in one clock edge. A write presented in the same cycle lands in the outgoing mode's view before the exchange. A qualifier on each read and write port reaches the User/System copies from a privileged mode, as a forced user transfer needs.

Every access completes in the cycle it is presented. There is no handshake and no back-pressure, so all pins are plain control or data.

Top module: `rbk_regfile`

## Requirements
- R1: After reset the mode reads System (5'b11111), register 13 reads 0x03007F00 and register 15 reads 0x08000000. The IRQ copy of register 13 holds 0x03007FA0, the Supervisor copy holds 0x03007FE0, and every other register, copy and saved-status word is zero.
- R2: Registers 0 to 7 and 15 are one physical register seen identically in every mode.
- R3: Registers 8 to 12 have a fast-interrupt copy (used while the mode is 5'b10001) and one copy shared by all other modes.
- R4: Registers 13 and 14 have six copies: User/System shared, Supervisor, Abort, Undefined, IRQ and fast-interrupt.
- R5: The saved-status port reads and writes a separate word for each of Supervisor, Abort, Undefined, IRQ and fast-interrupt. The word is kept across mode changes.
- R6: In User or System mode, a saved-status read or write raises `spsr_err` in that cycle, the write is discarded, and `spsr_rdata` reads zero.
- R7: Mode encodings are User 10000, fast-interrupt 10001, IRQ 10010, Supervisor 10011, Abort 10111, Undefined 11011 and System 11111. A request carrying any other value raises `bad_mode` in that cycle and changes neither the mode nor any register.
- R8: With the read qualifier set, registers 8 to 12 in fast-interrupt mode return the non-fast-interrupt copy. Registers 13 and 14 in any mode other than User or System return the User/System copy. Otherwise the qualifier has no effect.
- R9: With the write qualifier set, writes are redirected to the same copies as R8 describes.
- R10: When a write and a valid mode change share a cycle, the write goes to the copy visible in the outgoing mode, and the exchange follows.
- R11: A read in the cycle of a write to the same register returns the old value. The new value is visible from the next cycle.
- R12: A valid mode change is visible on `cur_mode`, and in the register views, from the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_user | input | 1 | Read port A user-copy qualifier |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_user | input | 1 | Read port B user-copy qualifier |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Write register number |
| wr_user | input | 1 | Write user-copy qualifier |
| wr_data | input | 32 | Write data |
| mode_req | input | 1 | Mode-change request |
| mode_new | input | 5 | Requested mode encoding |
| cur_mode | output | 5 | Current mode |
| bad_mode | output | 1 | Request carries an unknown encoding |
| spsr_re | input | 1 | Saved-status read strobe (used for error flagging) |
| spsr_we | input | 1 | Saved-status write enable |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Saved-status word of the current mode |
| spsr_err | output | 1 | Saved-status access in a mode without one |

## Verification
Directed sequences walk the reset-time stack copies by entering IRQ and Supervisor. A write placed in the same cycle as a fast-interrupt exit shows whether writes land before or after the exchange. Qualified reads and writes are tried in fast-interrupt, privileged and User modes, so a redirect applied in the wrong mode is caught. Random cycles then mix writes, qualified reads, saved-status traffic and mode requests, including unknown encodings. A reference that keeps every physical copy in place, with no swapping, tells a wrong exchange apart from a wrong read mux.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int NREG    = 16;
  localparam int IDXW    = $clog2(NREG);
  localparam int MODEW   = 5;
  localparam int NHI     = 5;   // registers 8..12
  localparam int HI_LO   = 8;
  localparam int NSTK    = 2;   // registers 13..14
  localparam int STK_LO  = 13;
  localparam int NSTKB   = 6;   // stack-pair copies
  localparam int NSAVED  = 5;   // saved-status words
  localparam int SLOTW   = 3;

  typedef enum logic [MODEW-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  // stack-pair slot numbers (slot 0 = User/System)
  localparam logic [SLOTW-1:0] STK_USR = 3'd0;
  localparam logic [SLOTW-1:0] STK_SVC = 3'd1;
  localparam logic [SLOTW-1:0] STK_ABT = 3'd2;
  localparam logic [SLOTW-1:0] STK_UND = 3'd3;
  localparam logic [SLOTW-1:0] STK_IRQ = 3'd4;
  localparam logic [SLOTW-1:0] STK_FIQ = 3'd5;

  typedef struct packed {
    logic             valid;
    logic             fiq;
    logic             has_saved;
    logic [SLOTW-1:0] stk_slot;
    logic [SLOTW-1:0] sav_slot;
  } mode_info_t;
endpackage

// File: rtl/rbk_mode_decode.sv
module rbk_mode_decode
  import rbk_pkg::*;
(
  input  logic [MODEW-1:0] mode_i,
  output mode_info_t       info_o
);
  always_comb begin
    info_o = '0;
    unique case (mode_i)
      M_USR, M_SYS: begin
        info_o.valid    = 1'b1;
        info_o.stk_slot = STK_USR;
      end
      M_SVC: begin
        info_o = '{valid: 1'b1, fiq: 1'b0, has_saved: 1'b1, stk_slot: STK_SVC, sav_slot: 3'd0};
      end
      M_ABT: begin
        info_o = '{valid: 1'b1, fiq: 1'b0, has_saved: 1'b1, stk_slot: STK_ABT, sav_slot: 3'd1};
      end
      M_UND: begin
        info_o = '{valid: 1'b1, fiq: 1'b0, has_saved: 1'b1, stk_slot: STK_UND, sav_slot: 3'd2};
      end
      M_IRQ: begin
        info_o = '{valid: 1'b1, fiq: 1'b0, has_saved: 1'b1, stk_slot: STK_IRQ, sav_slot: 3'd3};
      end
      M_FIQ: begin
        info_o = '{valid: 1'b1, fiq: 1'b1, has_saved: 1'b1, stk_slot: STK_FIQ, sav_slot: 3'd4};
      end
      default: info_o = '0;
    endcase
  end
endmodule

// File: rtl/rbk_read_port.sv
module rbk_read_port
  import rbk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [NREG-1:0][DW-1:0] act_i,
  input  logic [NHI-1:0][DW-1:0]  hi_usr_i,
  input  logic [NSTK-1:0][DW-1:0] stk_usr_i,
  input  logic                    cur_fiq_i,
  input  logic                    cur_usrsys_i,
  input  logic [IDXW-1:0]         idx_i,
  input  logic                    user_i,
  output logic [DW-1:0]           data_o
);
  logic in_hi, in_stk;
  logic [SLOTW-1:0] hi_off;
  logic             stk_off;

  assign in_hi   = (idx_i >= IDXW'(HI_LO)) && (idx_i < IDXW'(HI_LO + NHI));
  assign in_stk  = (idx_i >= IDXW'(STK_LO)) && (idx_i < IDXW'(STK_LO + NSTK));
  assign hi_off  = SLOTW'(idx_i - IDXW'(HI_LO));
  assign stk_off = 1'(idx_i - IDXW'(STK_LO));

  always_comb begin
    data_o = act_i[idx_i];
    if (user_i && in_hi && cur_fiq_i)
      data_o = hi_usr_i[hi_off];
    else if (user_i && in_stk && !cur_usrsys_i)
      data_o = stk_usr_i[stk_off];
  end
endmodule

// File: rtl/rbk_bank_store.sv
module rbk_bank_store
  import rbk_pkg::*;
#(
  parameter int            DW         = 32,
  parameter logic [DW-1:0] RST_STK    = 32'h0300_7F00,
  parameter logic [DW-1:0] RST_PC     = 32'h0800_0000,
  parameter logic [DW-1:0] RST_STK_IQ = 32'h0300_7FA0,
  parameter logic [DW-1:0] RST_STK_SV = 32'h0300_7FE0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDXW-1:0]         wr_idx,
  input  logic                    wr_user,
  input  logic [DW-1:0]           wr_data,
  input  logic                    sav_we,
  input  logic [DW-1:0]           sav_wdata,
  input  logic                    swap,
  input  logic                    cur_fiq,
  input  logic [SLOTW-1:0]        cur_stk,
  input  logic                    cur_has,
  input  logic [SLOTW-1:0]        cur_sav,
  input  logic                    nxt_fiq,
  input  logic [SLOTW-1:0]        nxt_stk,
  input  logic                    nxt_has,
  input  logic [SLOTW-1:0]        nxt_sav,
  output logic [NREG-1:0][DW-1:0] act_o,
  output logic [NHI-1:0][DW-1:0]  hi_usr_o,
  output logic [NSTK-1:0][DW-1:0] stk_usr_o,
  output logic [DW-1:0]           sav_o
);
  localparam int PC_IDX = NREG - 1;

  logic [NREG-1:0][DW-1:0]           act_q, act_w, act_n;
  logic [1:0][NHI-1:0][DW-1:0]       hib_q, hib_w, hib_n;
  logic [NSTKB-1:0][NSTK-1:0][DW-1:0] stkb_q, stkb_w, stkb_n;
  logic [NSAVED-1:0][DW-1:0]         savb_q, savb_n;
  logic [DW-1:0]                     sav_q, sav_w, sav_n;

  logic             w_hi, w_stk;
  logic [SLOTW-1:0] w_hi_off;
  logic             w_stk_off;

  assign w_hi      = (wr_idx >= IDXW'(HI_LO)) && (wr_idx < IDXW'(HI_LO + NHI));
  assign w_stk     = (wr_idx >= IDXW'(STK_LO)) && (wr_idx < IDXW'(STK_LO + NSTK));
  assign w_hi_off  = SLOTW'(wr_idx - IDXW'(HI_LO));
  assign w_stk_off = 1'(wr_idx - IDXW'(STK_LO));

  // stage 1: the write, seen from the current mode
  always_comb begin
    act_w  = act_q;
    hib_w  = hib_q;
    stkb_w = stkb_q;
    sav_w  = sav_q;
    if (wr_en) begin
      if (wr_user && w_hi && cur_fiq)
        hib_w[0][w_hi_off] = wr_data;
      else if (wr_user && w_stk && (cur_stk != STK_USR))
        stkb_w[STK_USR][w_stk_off] = wr_data;
      else
        act_w[wr_idx] = wr_data;
    end
    if (sav_we && cur_has)
      sav_w = sav_wdata;
  end

  // stage 2: the exchange between live set and copies
  always_comb begin
    act_n  = act_w;
    hib_n  = hib_w;
    stkb_n = stkb_w;
    savb_n = savb_q;
    sav_n  = sav_w;
    if (swap) begin
      for (int i = 0; i < NHI; i++)
        hib_n[cur_fiq][i] = act_w[HI_LO + i];
      for (int k = 0; k < NSTK; k++)
        stkb_n[cur_stk][k] = act_w[STK_LO + k];
      if (cur_has)
        savb_n[cur_sav] = sav_w;
      for (int i = 0; i < NHI; i++)
        act_n[HI_LO + i] = hib_n[nxt_fiq][i];
      for (int k = 0; k < NSTK; k++)
        act_n[STK_LO + k] = stkb_n[nxt_stk][k];
      if (nxt_has)
        sav_n = savb_n[nxt_sav];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q                  <= '0;
      act_q[STK_LO]          <= RST_STK;
      act_q[PC_IDX]          <= RST_PC;
      hib_q                  <= '0;
      stkb_q                 <= '0;
      stkb_q[STK_IRQ][0]     <= RST_STK_IQ;
      stkb_q[STK_SVC][0]     <= RST_STK_SV;
      savb_q                 <= '0;
      sav_q                  <= '0;
    end else begin
      act_q  <= act_n;
      hib_q  <= hib_n;
      stkb_q <= stkb_n;
      savb_q <= savb_n;
      sav_q  <= sav_n;
    end
  end

  assign act_o     = act_q;
  assign hi_usr_o  = hib_q[0];
  assign stk_usr_o = stkb_q[STK_USR];
  assign sav_o     = sav_q;
endmodule

// File: rtl/rbk_regfile.sv
module rbk_regfile
  import rbk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [rbk_pkg::IDXW-1:0]  rd_a_idx,
  input  logic                  rd_a_user,
  output logic [DW-1:0]         rd_a_data,
  input  logic [rbk_pkg::IDXW-1:0]  rd_b_idx,
  input  logic                  rd_b_user,
  output logic [DW-1:0]         rd_b_data,
  input  logic                  wr_en,
  input  logic [rbk_pkg::IDXW-1:0]  wr_idx,
  input  logic                  wr_user,
  input  logic [DW-1:0]         wr_data,
  input  logic                  mode_req,
  input  logic [rbk_pkg::MODEW-1:0] mode_new,
  output logic [rbk_pkg::MODEW-1:0] cur_mode,
  output logic                  bad_mode,
  input  logic                  spsr_re,
  input  logic                  spsr_we,
  input  logic [DW-1:0]         spsr_wdata,
  output logic [DW-1:0]         spsr_rdata,
  output logic                  spsr_err
);
  localparam int NRP = 2;

  logic [MODEW-1:0] mode_q;
  mode_info_t       cur, nxt;
  logic             swap;

  logic [NREG-1:0][DW-1:0] act;
  logic [NHI-1:0][DW-1:0]  hi_usr;
  logic [NSTK-1:0][DW-1:0] stk_usr;
  logic [DW-1:0]           sav;

  logic [NRP-1:0][IDXW-1:0] rp_idx;
  logic [NRP-1:0]           rp_user;
  logic [NRP-1:0][DW-1:0]   rp_data;

  rbk_mode_decode u_dec_cur (.mode_i(mode_q),   .info_o(cur));
  rbk_mode_decode u_dec_nxt (.mode_i(mode_new), .info_o(nxt));

  assign swap     = mode_req & nxt.valid;
  assign bad_mode = mode_req & ~nxt.valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= M_SYS;
    else if (swap)
      mode_q <= mode_new;
  end
  assign cur_mode = mode_q;

  rbk_bank_store #(.DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_user   (wr_user),
    .wr_data   (wr_data),
    .sav_we    (spsr_we),
    .sav_wdata (spsr_wdata),
    .swap      (swap),
    .cur_fiq   (cur.fiq),
    .cur_stk   (cur.stk_slot),
    .cur_has   (cur.has_saved),
    .cur_sav   (cur.sav_slot),
    .nxt_fiq   (nxt.fiq),
    .nxt_stk   (nxt.stk_slot),
    .nxt_has   (nxt.has_saved),
    .nxt_sav   (nxt.sav_slot),
    .act_o     (act),
    .hi_usr_o  (hi_usr),
    .stk_usr_o (stk_usr),
    .sav_o     (sav)
  );

  assign rp_idx  = {rd_b_idx, rd_a_idx};
  assign rp_user = {rd_b_user, rd_a_user};

  for (genvar g = 0; g < NRP; g++) begin : g_rp
    rbk_read_port #(.DW(DW)) u_rp (
      .act_i        (act),
      .hi_usr_i     (hi_usr),
      .stk_usr_i    (stk_usr),
      .cur_fiq_i    (cur.fiq),
      .cur_usrsys_i (cur.stk_slot == STK_USR),
      .idx_i        (rp_idx[g]),
      .user_i       (rp_user[g]),
      .data_o       (rp_data[g])
    );
  end

  assign rd_a_data  = rp_data[0];
  assign rd_b_data  = rp_data[1];
  assign spsr_rdata = cur.has_saved ? sav : '0;
  assign spsr_err   = (spsr_re | spsr_we) & ~(cur.valid & cur.has_saved);
endmodule

// File: rtl/rbk_regfile_chk.sv
module rbk_regfile_chk
  import rbk_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_req,
  input logic [MODEW-1:0] mode_new,
  input logic [MODEW-1:0] cur_mode,
  input logic             bad_mode,
  input logic             spsr_err,
  input logic             wr_en,
  input logic [IDXW-1:0]  rd_a_idx,
  input logic [DW-1:0]    rd_a_data
);
  // R12
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !bad_mode) |=> (cur_mode == $past(mode_new)));

  // R7
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |=> $stable(cur_mode));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_req |=> $stable(cur_mode));

  // R7
  legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mode inside {M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS});

  // R6
  saved_err_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spsr_err |-> (cur_mode == M_USR || cur_mode == M_SYS));

  // R2
  unbanked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (rd_a_idx < IDXW'(8) || rd_a_idx == IDXW'(15)))
      |=> ((rd_a_idx != $past(rd_a_idx)) || $stable(rd_a_data)));
endmodule

bind rbk_regfile rbk_regfile_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_req  (mode_req),
  .mode_new  (mode_new),
  .cur_mode  (cur_mode),
  .bad_mode  (bad_mode),
  .spsr_err  (spsr_err),
  .wr_en     (wr_en),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data)
);

// File: tb/rbk_regfile_tb_top.sv
module rbk_regfile_tb_top;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010, SVC = 5'b10011,
                         ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic        rd_a_user, rd_b_user, wr_en, wr_user, mode_req, spsr_re, spsr_we;
  logic [31:0] rd_a_data, rd_b_data, wr_data, spsr_wdata, spsr_rdata;
  logic [4:0]  mode_new, cur_mode;
  logic        bad_mode, spsr_err;

  rbk_regfile dut_i (.*);

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_com [16];
  logic [31:0] m_hi  [2][5];
  logic [31:0] m_stk [6][2];
  logic [31:0] m_sav [5];
  logic [4:0]  m_mode;

  function automatic int stk_slot(logic [4:0] m);
    case (m)
      USR, SYS: return 0;
      SVC: return 1;
      ABT: return 2;
      UND: return 3;
      IRQ: return 4;
      FIQ: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int sav_slot(logic [4:0] m);
    case (m)
      SVC: return 0;
      ABT: return 1;
      UND: return 2;
      IRQ: return 3;
      FIQ: return 4;
      default: return -1;
    endcase
  endfunction

  // physical location id: <100 shared, 1xy hi copy x, 2xy stack copy x
  function automatic int loc(int idx, bit user);
    if (idx >= 8 && idx <= 12)
      return 100 + ((m_mode == FIQ && !user) ? 10 : 0) + (idx - 8);
    if (idx == 13 || idx == 14)
      return 200 + 10 * ((user && stk_slot(m_mode) != 0) ? 0 : stk_slot(m_mode)) + (idx - 13);
    return idx;
  endfunction

  function automatic logic [31:0] m_rd(int idx, bit user);
    int l = loc(idx, user);
    if (l >= 200) return m_stk[(l - 200) / 10][(l - 200) % 10];
    if (l >= 100) return m_hi[(l - 100) / 10][(l - 100) % 10];
    return m_com[l];
  endfunction

  function automatic void m_wr(int idx, bit user, logic [31:0] d);
    int l = loc(idx, user);
    if (l >= 200) m_stk[(l - 200) / 10][(l - 200) % 10] = d;
    else if (l >= 100) m_hi[(l - 100) / 10][(l - 100) % 10] = d;
    else m_com[l] = d;
  endfunction

  function automatic string tag_of(int idx, bit user);
    int l = loc(idx, user);
    if (l >= 200) return (user && stk_slot(m_mode) != 0) ? "R8" : "R4";
    if (l >= 100) return (user && m_mode == FIQ) ? "R8" : "R3";
    return "R2";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then advance one edge
  task automatic step(bit we, int widx, bit wu, logic [31:0] wd, bit mr, logic [4:0] mn,
                      bit sre, bit swe, logic [31:0] swd,
                      int ai, bit au, int bi, bit bu, string tag);
    int s;
    string ta, tb;
    wr_en = we; wr_idx = 4'(widx); wr_user = wu; wr_data = wd;
    mode_req = mr; mode_new = mn;
    spsr_re = sre; spsr_we = swe; spsr_wdata = swd;
    rd_a_idx = 4'(ai); rd_a_user = au; rd_b_idx = 4'(bi); rd_b_user = bu;
    #1;
    ta = (tag != "") ? tag : ((we && loc(widx, wu) == loc(ai, au)) ? "R11" : tag_of(ai, au));
    tb = (we && loc(widx, wu) == loc(bi, bu)) ? "R11" : tag_of(bi, bu);
    chk(ta, rd_a_data, m_rd(ai, au));
    chk(tb, rd_b_data, m_rd(bi, bu));
    s = sav_slot(m_mode);
    chk((s >= 0) ? "R5" : "R6", spsr_rdata, (s >= 0) ? m_sav[s] : 32'h0);
    chk("R6", 32'(spsr_err), 32'((sre || swe) && s < 0));
    chk("R7", 32'(bad_mode), 32'(mr && stk_slot(mn) < 0));
    chk("R12", 32'(cur_mode), 32'(m_mode));
    if (we) m_wr(widx, wu, wd);
    if (swe && s >= 0) m_sav[s] = swd;
    if (mr && stk_slot(mn) >= 0) m_mode = mn;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_rd(int ai, bit au, int bi, bit bu, string tag);
    step(0, 0, 0, 0, 0, SYS, 0, 0, 0, ai, au, bi, bu, tag);
  endtask

  task automatic go(logic [4:0] m);
    step(0, 0, 0, 0, 1, m, 0, 0, 0, 0, 0, 15, 0, "");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [4:0] legal [7] = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS};
    void'($urandom(32'd20240611));
    foreach (m_com[i]) m_com[i] = '0;
    foreach (m_hi[i, j]) m_hi[i][j] = '0;
    foreach (m_stk[i, j]) m_stk[i][j] = '0;
    foreach (m_sav[i]) m_sav[i] = '0;
    m_stk[0][0] = 32'h0300_7F00;
    m_stk[4][0] = 32'h0300_7FA0;
    m_stk[1][0] = 32'h0300_7FE0;
    m_com[15]   = 32'h0800_0000;
    m_mode      = SYS;

    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_user = 0; wr_data = 0; mode_req = 0; mode_new = SYS;
    spsr_re = 0; spsr_we = 0; spsr_wdata = 0;
    rd_a_idx = 0; rd_a_user = 0; rd_b_idx = 0; rd_b_user = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    idle_rd(13, 0, 15, 0, "R1");
    idle_rd(0, 0, 14, 0, "R1");
    go(IRQ);
    idle_rd(13, 0, 13, 1, "R1");
    go(SVC);
    idle_rd(13, 0, 12, 0, "R1");

    // R10: write in the exit cycle from FIQ lands in the FIQ copy
    go(FIQ);
    step(1, 8, 0, 32'hAAAA_0008, 1, USR, 0, 0, 0, 8, 0, 9, 0, "R10");
    idle_rd(8, 0, 13, 0, "R10");
    go(FIQ);
    idle_rd(8, 0, 8, 1, "R10");

    // R9: qualified write in FIQ reaches the shared copy
    step(1, 9, 1, 32'h0000_1234, 0, SYS, 0, 0, 0, 9, 0, 9, 1, "R9");
    idle_rd(9, 1, 9, 0, "R9");
    go(USR);
    idle_rd(9, 0, 9, 1, "R9");

    // R11: same-cycle read returns old, next cycle the new value
    step(1, 3, 0, 32'h5555_0003, 0, SYS, 0, 0, 0, 3, 0, 3, 0, "R11");
    idle_rd(3, 0, 3, 1, "R11");

    // R6: saved-status access in User
    step(0, 0, 0, 0, 0, SYS, 1, 1, 32'hFFFF_FFFF, 0, 0, 1, 0, "");
    go(ABT);
    step(0, 0, 0, 0, 0, SYS, 0, 1, 32'h0000_0055, 0, 0, 1, 0, "");
    go(IRQ);
    step(0, 0, 0, 0, 0, SYS, 1, 1, 32'h0000_0066, 0, 0, 1, 0, "");
    go(ABT);
    step(0, 0, 0, 0, 0, SYS, 1, 0, 0, 13, 0, 14, 0, "R5");

    // R7: unknown encodings are refused
    step(0, 0, 0, 0, 1, 5'b00000, 0, 0, 0, 13, 0, 14, 0, "R7");
    step(0, 0, 0, 0, 1, 5'b10100, 0, 0, 0, 13, 0, 14, 0, "R7");

    // R4: System and User share one stack pair
    go(SYS);
    step(1, 13, 0, 32'h0000_0077, 0, SYS, 0, 0, 0, 13, 0, 14, 0, "R4");
    go(USR);
    idle_rd(13, 0, 13, 1, "R4");

    // R8 in User: the qualifier changes nothing
    idle_rd(14, 1, 10, 1, "R8");

    for (int n = 0; n < 4000; n++) begin
      bit mr = ($urandom % 4) == 0;
      logic [4:0] mn = (($urandom % 8) == 0) ? 5'($urandom) : legal[$urandom % 7];
      step($urandom % 2, $urandom % 16, $urandom % 2, $urandom,
           mr, mn, $urandom % 2, ($urandom % 4) == 0, $urandom,
           $urandom % 16, $urandom % 2, $urandom % 16, $urandom % 2, "");
    end

    finish_run();
  end
endmodule